// File: doc/BRIEF.md
# I2C Target Register Port

This block lets an external I2C controller reach a byte-wide internal register memory. It filters the SCL and SDA inputs, decodes START, repeated START and STOP, matches a 7-bit target address, and drives a synchronous RAM port with an address, write data, a one-cycle write strobe and read data that arrives one clock after the address. SDA is only ever pulled low through an output enable. The pad or bus model supplies the pull-up.

A 16-bit pointer selects the RAM location. After the target address with the write bit, the controller sends the pointer as two bytes, upper byte first. Any further bytes in that transaction are stored at consecutive locations. If the controller issues STOP straight after the two pointer bytes, only the pointer changes. A transaction that uses the read bit streams bytes from wherever the pointer currently sits. To read from a chosen location, the controller sends the pointer in a write transaction, then a repeated START, then the address with the read bit. The pointer advances after every byte moved in either direction, wraps at the top of its range, and is kept from one transaction to the next.

The state machine has twelve states. IDLE waits for a START. DEV receives the address byte. PHI, PLO and WDAT receive the upper pointer byte, the lower pointer byte and data bytes. DEV_ACK, PHI_ACK, PLO_ACK and WDAT_ACK hold the acknowledge slot that follows each of those bytes. RDAT shifts a byte out, and RDAT_ACK samples the controller's reply. SKIP ignores the bus until the next START or STOP.

The transitions are as follows:
- A START in any state goes to DEV, and a STOP in any state goes to IDLE.
- At the end of the address byte, DEV moves to DEV_ACK if the address matches and to SKIP if it does not.
- DEV_ACK moves to RDAT when the read bit was set and to PHI when it was clear.
- The write path runs PHI → PHI_ACK → PLO → PLO_ACK → WDAT → WDAT_ACK, and then loops back to WDAT for each further byte.
- The read path runs RDAT → RDAT_ACK. From RDAT_ACK it returns to RDAT if the controller acknowledged and goes to SKIP if it did not.

Top module: `i2c_regport`

## Requirements
- R1: After reset the SDA output enable is 0, the write strobe `mem_we` is 0 and `mem_addr` (the pointer) is 0x0000.
- R2: The address byte is taken MSB first. Its upper seven bits are the target address and bit 0 is the direction (1 means read). A match with `DEV_ADDR` is acknowledged by pulling SDA low during the ninth clock. A mismatch is not acknowledged, and every later byte of that transaction is left unacknowledged and causes no RAM write.
- R3: In a write transaction, the first byte after the address is pointer bits 15:8 and the second is bits 7:0. Each further byte is acknowledged and written with a one-cycle `mem_we` at the pointer, and the pointer then increases by one.
- R4: A write transaction that ends with STOP right after the two pointer bytes produces no RAM write and leaves the pointer at the value sent.
- R5: A read transaction returns the RAM contents starting at the current pointer, MSB first, one location further for each byte. The pointer is kept across transactions.
- R6: A repeated START after the pointer bytes, followed by the address with the read bit, streams data from the new pointer.
- R7: The pointer wraps from 0xFFFF to 0x0000 on both writes and reads.
- R8: When the controller does not acknowledge a read byte, the target releases SDA and drives nothing more until the next START or STOP. The pointer has advanced only for the bytes actually shifted out.
- R9: A pulse on SCL or SDA shorter than `FILT_LEN` system clocks is ignored. It causes no bit, START or STOP.
- R10: The target only asserts its SDA drive while the filtered SCL is low. It never drives SDA high.
- R11: A START in the middle of a byte restarts address reception without changing the pointer. A STOP returns the target to IDLE with SDA released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain); 0 releases it |
| mem_addr | output | 16 | RAM address, equal to the pointer |
| mem_wdata | output | 8 | RAM write data |
| mem_we | output | 1 | One-cycle RAM write strobe |
| mem_rdata | input | 8 | RAM read data, valid one clock after mem_addr |

## Verification
The hardest cases to reach from the ports are the ones where the bus does something unusual in the middle of a transfer. One is a START arriving partway through a pointer byte. Another is the controller clocking a further byte after it has refused an earlier one. The bench reaches both by driving SCL and SDA bit by bit, with its own open-drain model of the line. For the START case it sends four bits of a byte and then issues a repeated START. For the refused-byte case it clocks a byte after the NACK and checks that the line stays high.

Spikes are injected on SDA during the SCL high phase and on SCL during the low phase, while a burst write is in progress. The bench then checks that every stored address and data byte still matches. The pointer wrap is reached by writing a burst that starts at 0xFFFE and then reading back across the boundary.

// File: rtl/i2c_rp_pkg.sv
package i2c_rp_pkg;
    localparam int BYTE_W = 8;
    localparam int PTR_W  = 2 * BYTE_W;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_PHI,
        ST_PHI_ACK,
        ST_PLO,
        ST_PLO_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_RDAT_ACK,
        ST_SKIP
    } rp_state_e;
endpackage

// File: rtl/i2c_rp_glitch.sv
module i2c_rp_glitch #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;

    // Two-flop synchronizer, then the output follows only after
    // FILT_LEN consecutive samples disagree with it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
            dout   <= 1'b1;
            cnt_q  <= '0;
        end else begin
            sync_q <= {sync_q[0], din};
            if (sync_q[1] != dout) begin
                if (cnt_q == CW'(FILT_LEN - 1)) begin
                    dout  <= sync_q[1];
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                cnt_q <= '0;
            end
        end
    end
endmodule

// File: rtl/i2c_rp_busev.sv
module i2c_rp_busev (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    assign scl_rise = scl_f & ~scl_q;
    assign scl_fall = ~scl_f & scl_q;
    // SDA moving while SCL stays high marks a bus condition
    assign start_ev = scl_f & scl_q & sda_q & ~sda_f;
    assign stop_ev  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/i2c_regport.sv
module i2c_regport
    import i2c_rp_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h4A,
    parameter int         FILT_LEN = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_i,
    input  logic                sda_i,
    output logic                sda_oe,
    output logic [PTR_W-1:0]    mem_addr,
    output logic [BYTE_W-1:0]   mem_wdata,
    output logic                mem_we,
    input  logic [BYTE_W-1:0]   mem_rdata
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    // ---------------- input filtering ----------------
    logic [1:0] raw_lines;
    logic [1:0] filt_lines;
    logic       scl_filt, sda_filt;

    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_filt
        i2c_rp_glitch #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_lines[g]),
            .dout (filt_lines[g])
        );
    end

    assign scl_filt = filt_lines[0];
    assign sda_filt = filt_lines[1];

    logic scl_rise, scl_fall, start_ev, stop_ev;

    i2c_rp_busev u_ev (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_f   (scl_filt),
        .sda_f   (sda_filt),
        .scl_rise(scl_rise),
        .scl_fall(scl_fall),
        .start_ev(start_ev),
        .stop_ev (stop_ev)
    );

    // ---------------- state ----------------
    rp_state_e            st, st_nxt;
    logic [CNT_W-1:0]     bit_cnt;
    logic [BYTE_W-1:0]    rx_sh, tx_sh, hi_q;
    logic [PTR_W-1:0]     ptr_q;
    logic                 rw_q, more_q;
    logic                 byte_end;
    logic                 addr_hit;

    assign byte_end = scl_fall && (bit_cnt == FULL);
    assign addr_hit = (rx_sh[7:1] == DEV_ADDR);
    assign mem_addr = ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        if (start_ev) begin
            st_nxt = ST_DEV;
        end else if (stop_ev) begin
            st_nxt = ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE:     st_nxt = ST_IDLE;
                ST_DEV:      if (byte_end) st_nxt = addr_hit ? ST_DEV_ACK : ST_SKIP;
                ST_DEV_ACK:  if (scl_fall) st_nxt = rw_q ? ST_RDAT : ST_PHI;
                ST_PHI:      if (byte_end) st_nxt = ST_PHI_ACK;
                ST_PHI_ACK:  if (scl_fall) st_nxt = ST_PLO;
                ST_PLO:      if (byte_end) st_nxt = ST_PLO_ACK;
                ST_PLO_ACK:  if (scl_fall) st_nxt = ST_WDAT;
                ST_WDAT:     if (byte_end) st_nxt = ST_WDAT_ACK;
                ST_WDAT_ACK: if (scl_fall) st_nxt = ST_WDAT;
                ST_RDAT:     if (byte_end) st_nxt = ST_RDAT_ACK;
                ST_RDAT_ACK: if (scl_fall) st_nxt = more_q ? ST_RDAT : ST_SKIP;
                ST_SKIP:     st_nxt = ST_SKIP;
                default:     st_nxt = ST_IDLE;
            endcase
        end
    end

    // ---------------- outputs and datapath ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe    <= 1'b0;
            mem_we    <= 1'b0;
            mem_wdata <= '0;
            ptr_q     <= '0;
            bit_cnt   <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            hi_q      <= '0;
            rw_q      <= 1'b0;
            more_q    <= 1'b0;
        end else begin
            mem_we <= 1'b0;
            // a write strobe is followed by the pointer step
            if (mem_we) ptr_q <= ptr_q + 1'b1;

            if (start_ev || stop_ev) begin
                sda_oe  <= 1'b0;
                bit_cnt <= '0;
            end else begin
                unique case (st)
                    ST_DEV, ST_PHI, ST_PLO, ST_WDAT: begin
                        if (scl_rise && bit_cnt != FULL) begin
                            rx_sh   <= {rx_sh[BYTE_W-2:0], sda_filt};
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                        if (byte_end) begin
                            bit_cnt <= '0;
                            sda_oe  <= 1'b1;
                            if (st == ST_DEV) begin
                                rw_q   <= rx_sh[0];
                                sda_oe <= addr_hit;
                            end
                            if (st == ST_PHI) hi_q <= rx_sh;
                            if (st == ST_PLO) ptr_q <= {hi_q, rx_sh};
                            if (st == ST_WDAT) begin
                                mem_wdata <= rx_sh;
                                mem_we    <= 1'b1;
                            end
                        end
                    end
                    ST_DEV_ACK, ST_PHI_ACK, ST_PLO_ACK, ST_WDAT_ACK: begin
                        if (scl_fall) begin
                            sda_oe  <= 1'b0;
                            bit_cnt <= '0;
                            if (st == ST_DEV_ACK && rw_q) begin
                                tx_sh  <= mem_rdata;
                                sda_oe <= ~mem_rdata[BYTE_W-1];
                            end
                        end
                    end
                    ST_RDAT: begin
                        if (scl_rise && bit_cnt != FULL) bit_cnt <= bit_cnt + 1'b1;
                        if (scl_fall) begin
                            if (bit_cnt == FULL) begin
                                sda_oe <= 1'b0;
                                ptr_q  <= ptr_q + 1'b1;
                            end else begin
                                tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~tx_sh[BYTE_W-2];
                            end
                        end
                    end
                    ST_RDAT_ACK: begin
                        if (scl_rise) more_q <= ~sda_filt;
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (more_q) begin
                                tx_sh  <= mem_rdata;
                                sda_oe <= ~mem_rdata[BYTE_W-1];
                            end
                        end
                    end
                    ST_IDLE, ST_SKIP: sda_oe <= 1'b0;
                    default:          sda_oe <= 1'b0;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_regport_chk.sv
module i2c_regport_chk
    import i2c_rp_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input rp_state_e        st,
    input logic             scl_f,
    input logic             sda_oe,
    input logic             mem_we,
    input logic [PTR_W-1:0] mem_addr
);
    // R10: a new drive of SDA starts only while filtered SCL is low
    a_r10_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe && !$stable(sda_oe)) |-> !scl_f);

    // R11: idle means released
    a_r11_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !sda_oe);

    // R3: strobe lasts one cycle and the pointer then steps by one
    a_r3_we_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    a_r3_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (mem_addr == $past(mem_addr) + 1'b1));

    // R4: writes only come out of a data byte
    a_r4_we_from_data: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (st == ST_WDAT_ACK));

    // R2: an ignored transaction neither drives nor writes
    a_r2_skip_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SKIP) |-> (!sda_oe && !mem_we));

    // R8: the controller owns SDA in the read acknowledge slot
    a_r8_rdack_released: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RDAT_ACK) |-> !sda_oe);
endmodule

bind i2c_regport i2c_regport_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .st      (st),
    .scl_f   (scl_filt),
    .sda_oe  (sda_oe),
    .mem_we  (mem_we),
    .mem_addr(mem_addr)
);

// File: tb/tb_i2c_regport.sv
module tb_i2c_regport;
    localparam logic [6:0] DEV = 7'h4A;
    localparam int Q = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_oe;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic [7:0]  mem_rdata = 8'h00;
    logic        sda_line;

    int vec = 0;
    int bad = 0;

    logic [7:0]  ram [256];
    int          wcount = 0;
    logic [15:0] last_wa = '0;
    logic [7:0]  last_wd = '0;

    always #2 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    i2c_regport #(.DEV_ADDR(DEV), .FILT_LEN(3)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .sda_oe   (sda_oe),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .mem_we   (mem_we),
        .mem_rdata(mem_rdata)
    );

    // bench RAM indexed by the low pointer byte
    always @(posedge clk) begin
        if (mem_we) begin
            ram[mem_addr[7:0]] <= mem_wdata;
            wcount  <= wcount + 1;
            last_wa <= mem_addr;
            last_wd <= mem_wdata;
        end
        mem_rdata <= ram[mem_addr[7:0]];
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vec++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_bit(input bit b, input bit glitch);
        sda_m = b; tick(Q);
        scl_m = 1'b1;
        if (glitch && b) begin
            tick(Q / 2); sda_m = 1'b0; tick(1); sda_m = 1'b1; tick(Q - Q / 2 - 1);
        end else tick(Q);
        tick(Q);
        scl_m = 1'b0;
        if (glitch) begin
            tick(Q / 2); scl_m = 1'b1; tick(1); scl_m = 1'b0; tick(Q - Q / 2 - 1);
        end else tick(Q);
    endtask

    task automatic wr_byte(input logic [7:0] b, input bit glitch, output bit ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i], glitch);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        ack = ~sda_line; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic rd_byte(input bit give_ack, output logic [7:0] d);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q); scl_m = 1'b1; tick(Q);
            d[i] = sda_line; tick(Q);
            scl_m = 1'b0; tick(Q);
        end
        send_bit(~give_ack, 1'b0);
    endtask

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 5) ^ 8'h90);
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        bit          ack;
        logic [7:0]  d;
        int          w0;
        for (int i = 0; i < 256; i++) ram[i] = 8'h00;
        tick(5);
        rst_n = 1'b1;
        tick(2);
        // R1 reset state
        chk(sda_oe == 1'b0, "R1 oe", int'(sda_oe), 0);
        chk(mem_we == 1'b0, "R1 we", int'(mem_we), 0);
        chk(mem_addr == 16'h0000, "R1 ptr", int'(mem_addr), 0);

        // R2 sweep of every address with the write bit
        for (int a = 0; a < 128; a++) begin
            bus_start();
            wr_byte({7'(a), 1'b0}, 1'b0, ack);
            bus_stop();
            chk(ack == (7'(a) == DEV), "R2 addr ack", int'(ack), int'(7'(a) == DEV));
        end
        chk(wcount == 0, "R2 no write in sweep", wcount, 0);

        // R2 mismatch with payload is ignored
        bus_start();
        wr_byte({DEV ^ 7'h01, 1'b0}, 1'b0, ack);
        chk(!ack, "R2 mismatch nack", int'(ack), 0);
        wr_byte(8'h12, 1'b0, ack); chk(!ack, "R2 payload nack", int'(ack), 0);
        wr_byte(8'h30, 1'b0, ack); chk(!ack, "R2 payload nack", int'(ack), 0);
        wr_byte(8'hAA, 1'b0, ack); chk(!ack, "R2 payload nack", int'(ack), 0);
        bus_stop();
        chk(wcount == 0, "R2 mismatch no write", wcount, 0);
        chk(sda_oe == 1'b0, "R11 released after stop", int'(sda_oe), 0);

        // R3 burst write at 0x1230, R9 spikes on odd bytes
        bus_start();
        wr_byte({DEV, 1'b0}, 1'b0, ack); chk(ack, "R3 dev ack", int'(ack), 1);
        wr_byte(8'h12, 1'b0, ack);       chk(ack, "R3 hi ack", int'(ack), 1);
        wr_byte(8'h30, 1'b0, ack);       chk(ack, "R3 lo ack", int'(ack), 1);
        for (int i = 0; i < 8; i++) begin
            wr_byte(pat(i), i[0], ack);
            chk(ack, "R3 data ack", int'(ack), 1);
            chk(wcount == i + 1, i[0] ? "R9 write count" : "R3 write count", wcount, i + 1);
            chk(last_wa == 16'h1230 + 16'(i), i[0] ? "R9 addr" : "R3 addr", int'(last_wa), 16'h1230 + i);
            chk(last_wd == pat(i), i[0] ? "R9 data" : "R3 data", int'(last_wd), int'(pat(i)));
        end
        bus_stop();

        // R4 pointer-only write
        w0 = wcount;
        bus_start();
        wr_byte({DEV, 1'b0}, 1'b0, ack);
        wr_byte(8'h12, 1'b0, ack);
        wr_byte(8'h32, 1'b0, ack);
        bus_stop();
        chk(wcount == w0, "R4 no write", wcount, w0);
        chk(mem_addr == 16'h1232, "R4 pointer", int'(mem_addr), 16'h1232);

        // R5 current-address read, pointer retained
        bus_start();
        wr_byte({DEV, 1'b1}, 1'b0, ack); chk(ack, "R5 dev ack", int'(ack), 1);
        rd_byte(1'b1, d); chk(d == pat(2), "R5 byte0", int'(d), int'(pat(2)));
        rd_byte(1'b0, d); chk(d == pat(3), "R5 byte1", int'(d), int'(pat(3)));
        bus_stop();
        bus_start();
        wr_byte({DEV, 1'b1}, 1'b0, ack);
        rd_byte(1'b0, d); chk(d == pat(4), "R5 retained", int'(d), int'(pat(4)));
        // R8 after NACK the line stays released
        rd_byte(1'b0, d); chk(d == 8'hFF, "R8 released", int'(d), 8'hFF);
        bus_stop();
        chk(mem_addr == 16'h1235, "R8 pointer", int'(mem_addr), 16'h1235);

        // R6 combined read at 0x1231
        bus_start();
        wr_byte({DEV, 1'b0}, 1'b0, ack);
        wr_byte(8'h12, 1'b0, ack);
        wr_byte(8'h31, 1'b0, ack);
        bus_start();
        wr_byte({DEV, 1'b1}, 1'b0, ack); chk(ack, "R6 dev ack", int'(ack), 1);
        for (int i = 1; i < 4; i++) begin
            rd_byte(i != 3, d);
            chk(d == pat(i), "R6 data", int'(d), int'(pat(i)));
        end
        bus_stop();

        // R7 write wraps
        bus_start();
        wr_byte({DEV, 1'b0}, 1'b0, ack);
        wr_byte(8'hFF, 1'b0, ack);
        wr_byte(8'hFE, 1'b0, ack);
        for (int i = 0; i < 4; i++) begin
            wr_byte(8'hC1 + 8'(i), 1'b0, ack);
            chk(last_wa == 16'hFFFE + 16'(i), "R7 write addr", int'(last_wa), (16'hFFFE + i) & 16'hFFFF);
        end
        bus_stop();
        // R7 read wraps
        bus_start();
        wr_byte({DEV, 1'b0}, 1'b0, ack);
        wr_byte(8'hFF, 1'b0, ack);
        wr_byte(8'hFF, 1'b0, ack);
        bus_start();
        wr_byte({DEV, 1'b1}, 1'b0, ack);
        rd_byte(1'b0, d); chk(d == 8'hC2, "R7 read FFFF", int'(d), 8'hC2);
        bus_stop();
        bus_start();
        wr_byte({DEV, 1'b1}, 1'b0, ack);
        rd_byte(1'b0, d); chk(d == 8'hC3, "R7 read 0000", int'(d), 8'hC3);
        bus_stop();

        // R11 START mid pointer byte keeps pointer 0x0001
        bus_start();
        wr_byte({DEV, 1'b0}, 1'b0, ack);
        for (int i = 0; i < 4; i++) send_bit(1'b0, 1'b0);
        bus_start();
        wr_byte({DEV, 1'b1}, 1'b0, ack); chk(ack, "R11 restart ack", int'(ack), 1);
        rd_byte(1'b0, d); chk(d == 8'hC4, "R11 pointer kept", int'(d), 8'hC4);
        bus_stop();
        chk(sda_oe == 1'b0, "R10 only low drive, released at end", int'(sda_oe), 0);

        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end
endmodule